// File: doc/BRIEF.md
# Single-Descriptor Buffer DMA Engine

This engine moves one buffer of bytes between system memory and a byte-wide flash data path. Its work order comes from a small descriptor in memory, not from registers. Software places a 16-byte descriptor in memory. The descriptor holds a control/status word, a sizes word, a primary buffer pointer and a spare pointer. Software writes the descriptor's address into the engine's base register. It then pulses `start`, giving a direction and a byte count. The engine reads the descriptor over a 64-bit memory request port and checks that the descriptor is handed to it. It then either streams the buffer out to the transmit byte stream or gathers receive bytes into the buffer. Finally it returns the descriptor to software by clearing the ownership bit in the status word it writes back.

Completion and the "descriptor not handed over" condition are reported in a sticky status vector, which software clears bit by bit. The memory side moves whole 8-byte beats. A buffer is therefore covered by whole beats, and on a receive transfer the lanes of the final beat beyond the byte count are left unwritten.

The controller is one state machine:
- IDLE (`ST_IDLE`) waits for `start`.
- DESC_LO (`ST_D0_REQ`) and DESC_LO_WAIT (`ST_D0_WAIT`) fetch the first descriptor beat.
- DESC_HI (`ST_D1_REQ`) and DESC_HI_WAIT (`ST_D1_WAIT`) fetch the pointer beat.
- BEAT_RD (`ST_BUF_RD`) and BEAT_RD_WAIT (`ST_BUF_WAIT`) read a buffer beat, and TX_EMIT (`ST_TX_EMIT`) sends its bytes.
- RX_FILL (`ST_RX_FILL`) packs received bytes, and BEAT_WR (`ST_BUF_WR`) stores a packed beat.
- STAT_WB (`ST_STAT_WB`) returns the descriptor.
- FINISH (`ST_FINISH`) and NOT_OWNED (`ST_NOT_OWNED`) post status.

The transitions are:
- IDLE→DESC_LO on start.
- DESC_LO→DESC_LO_WAIT on grant.
- DESC_LO_WAIT→DESC_HI when the owner bit is set, →NOT_OWNED when it is clear.
- DESC_HI→DESC_HI_WAIT on grant.
- DESC_HI_WAIT→BEAT_RD for transmit, →RX_FILL for receive.
- BEAT_RD→BEAT_RD_WAIT on grant, and BEAT_RD_WAIT→TX_EMIT on read data.
- TX_EMIT→STAT_WB on the last byte, →BEAT_RD at the end of a beat.
- RX_FILL→BEAT_WR on the last byte or at a full beat.
- BEAT_WR→RX_FILL while bytes remain, →STAT_WB when none remain.
- STAT_WB→FINISH on grant, FINISH→IDLE and NOT_OWNED→IDLE.

Top module: `sdma_engine`

## Requirements
- R1: A configuration write to offset 0x18 loads the descriptor base address. Writes to any other offset leave it unchanged.
- R2: After `start`, the engine reads the descriptor as two 64-bit beats, at base and at base+8. The status word is bits 31:0 of the first beat and buffer pointer 0 is bits 31:0 of the second. A request is held with a stable address until it is granted.
- R3: If status bit 31 (owner) is clear, the engine reads only the first descriptor beat and makes no write. It moves no stream byte and sets status bit 8.
- R4: On a transmit transfer (`start_dir`=0), the engine reads ceil(N/8) beats from buffer pointer 0 upward. It emits exactly N bytes, lane 0 (bits 7:0) of each beat first. While not accepted, a byte stays valid and stable.
- R5: On a receive transfer (`start_dir`=1), the engine accepts exactly N bytes, even if more are offered. It writes ceil(N/8) beats with byte k at lane k mod 8. Every beat except the last carries all strobes. The last beat has strobes only for the lanes that hold data, so pad bytes are not written.
- R6: After the data phase, the engine writes the status word back to base with byte strobes 0x0F, bit 31 cleared and all other bits unchanged. The sizes word is not modified.
- R7: Completion sets status bit 6 for transmit and bit 7 for receive. At most one status event is raised per cycle.
- R8: Status bits are sticky and are cleared by a one-cycle pulse on the matching `sts_clr` bit. If a set and a clear hit the same bit in one cycle, the set wins.
- R9: While `busy` is high, `start` is ignored.
- R10: The byte count is N = `start_len_m1`+1 (1 to 4096). The descriptor sizes field is not used to count, so a size masked to 0 still moves N bytes.
- R11: After reset, `busy`, `tx_valid`, `rx_ready`, `mem_req` and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| start_i | input | 1 | Start pulse |
| start_dir | input | 1 | 0 = memory to stream, 1 = stream to memory |
| start_len_m1 | input | 12 | Byte count minus one |
| busy | output | 1 | Transfer in progress |
| sts_o | output | 16 | Sticky status bits |
| sts_clr | input | 16 | Write-one-to-clear pulse per status bit |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Beat-aligned byte address |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Byte strobes of a write |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit byte accepted |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte accepted |

## Verification
Two events can land on one status bit in one cycle: the FINISH state posting completion, and software clearing that same bit. The bench provokes this by holding the transmit-complete clear bit high through a whole transfer. The FINISH cycle therefore always sees a set and a clear together. The bench judges the result by sampling `sts_o` right after `busy` falls, where bit 6 must read 1, and one cycle later, where the still-held clear must have removed it.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_D0_REQ,
        ST_D0_WAIT,
        ST_D1_REQ,
        ST_D1_WAIT,
        ST_BUF_RD,
        ST_BUF_WAIT,
        ST_TX_EMIT,
        ST_RX_FILL,
        ST_BUF_WR,
        ST_STAT_WB,
        ST_FINISH,
        ST_NOT_OWNED
    } sdma_state_e;

    localparam int unsigned OWNER_BIT    = 31;
    localparam int unsigned EVT_TX_DONE  = 6;
    localparam int unsigned EVT_RX_DONE  = 7;
    localparam int unsigned EVT_NO_DESC  = 8;
    localparam logic [7:0]  OFS_DESC_BASE = 8'h18;

endpackage

// File: rtl/sdma_beat_buf.sv
module sdma_beat_buf #(
    parameter int unsigned BYTES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [BYTES*8-1:0]   load_data_i,
    input  logic                 restart_i,
    input  logic                 put_i,
    input  logic [7:0]           put_byte_i,
    input  logic                 take_i,
    output logic [BYTES*8-1:0]   beat_o,
    output logic [BYTES-1:0]     strb_o,
    output logic [7:0]           byte_o,
    output logic                 lane_last_o
);
    localparam int unsigned LW = (BYTES > 1) ? $clog2(BYTES) : 1;

    logic [LW-1:0] idx_q;
    logic [7:0]    lane_q [BYTES];
    logic          fill_q [BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load_i || restart_i) begin
            idx_q <= '0;
        end else if (put_i || take_i) begin
            idx_q <= idx_q + LW'(1);
        end
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic hit;
        assign hit = (idx_q == LW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
                fill_q[g] <= 1'b0;
            end else if (load_i) begin
                lane_q[g] <= load_data_i[g*8 +: 8];
                fill_q[g] <= 1'b0;
            end else if (restart_i) begin
                fill_q[g] <= 1'b0;
            end else if (put_i && hit) begin
                lane_q[g] <= put_byte_i;
                fill_q[g] <= 1'b1;
            end
        end

        assign beat_o[g*8 +: 8] = lane_q[g];
        assign strb_o[g]        = fill_q[g];
    end

    assign byte_o      = lane_q[idx_q];
    assign lane_last_o = (idx_q == LW'(BYTES - 1));

    // R5
    put_take_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(put_i && take_i));

    // R5
    strb_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        put_i && !restart_i && !load_i |=> strb_o[idx_q - LW'(1)]);

endmodule

// File: rtl/sdma_sts_reg.sv
module sdma_sts_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= (q_r & ~clr_i) | set_i;
    end

    assign q_o = q_r;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((q_r & $past(set_i)) == $past(set_i)));

    // R7
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_i));

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BUS_BYTES = 8,
    parameter int unsigned LEN_W     = 12,
    parameter int unsigned STS_W     = 16,
    parameter int unsigned CFG_AW    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [31:0]            cfg_wdata,
    input  logic                   start_i,
    input  logic                   start_dir,
    input  logic [LEN_W-1:0]       start_len_m1,
    output logic                   busy,
    output logic [STS_W-1:0]       sts_o,
    input  logic [STS_W-1:0]       sts_clr,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [BUS_BYTES*8-1:0] mem_wdata,
    output logic [BUS_BYTES-1:0]   mem_be,
    input  logic                   mem_gnt,
    input  logic                   mem_rvalid,
    input  logic [BUS_BYTES*8-1:0] mem_rdata,
    output logic                   tx_valid,
    output logic [7:0]             tx_data,
    input  logic                   tx_ready,
    input  logic                   rx_valid,
    input  logic [7:0]             rx_data,
    output logic                   rx_ready
);
    localparam int unsigned BUS_W = BUS_BYTES * 8;
    localparam int unsigned CNT_W = LEN_W + 1;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BUS_BYTES);
    localparam logic [BUS_BYTES-1:0] WB_BE = BUS_BYTES'(4'hF);

    sdma_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic [31:0]       dstat_q;
    logic              dir_q;

    logic             buf_load, buf_restart, buf_put, buf_take, lane_last;
    logic [BUS_W-1:0] buf_beat;
    logic [BUS_BYTES-1:0] buf_strb;
    logic [7:0]       buf_byte;
    logic [STS_W-1:0] evt_set;
    logic             tx_fire, rx_fire, last_byte;

    logic unused_rdata_hi;
    assign unused_rdata_hi = ^mem_rdata[BUS_W-1:32];

    assign tx_fire   = tx_valid && tx_ready;
    assign rx_fire   = rx_valid && rx_ready;
    assign last_byte = (rem_q == CNT_W'(1));

    sdma_beat_buf #(.BYTES(BUS_BYTES)) beat_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (buf_load),
        .load_data_i (mem_rdata),
        .restart_i   (buf_restart),
        .put_i       (buf_put),
        .put_byte_i  (rx_data),
        .take_i      (buf_take),
        .beat_o      (buf_beat),
        .strb_o      (buf_strb),
        .byte_o      (buf_byte),
        .lane_last_o (lane_last)
    );

    sdma_sts_reg #(.W(STS_W)) sts_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_set),
        .clr_i (sts_clr),
        .q_o   (sts_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_D0_REQ;
            ST_D0_REQ:    if (mem_gnt) state_d = ST_D0_WAIT;
            ST_D0_WAIT:   if (mem_rvalid)
                              state_d = mem_rdata[OWNER_BIT] ? ST_D1_REQ : ST_NOT_OWNED;
            ST_D1_REQ:    if (mem_gnt) state_d = ST_D1_WAIT;
            ST_D1_WAIT:   if (mem_rvalid) state_d = dir_q ? ST_RX_FILL : ST_BUF_RD;
            ST_BUF_RD:    if (mem_gnt) state_d = ST_BUF_WAIT;
            ST_BUF_WAIT:  if (mem_rvalid) state_d = ST_TX_EMIT;
            ST_TX_EMIT:   if (tx_fire) begin
                              if (last_byte)      state_d = ST_STAT_WB;
                              else if (lane_last) state_d = ST_BUF_RD;
                          end
            ST_RX_FILL:   if (rx_fire && (last_byte || lane_last)) state_d = ST_BUF_WR;
            ST_BUF_WR:    if (mem_gnt)
                              state_d = (rem_q == '0) ? ST_STAT_WB : ST_RX_FILL;
            ST_STAT_WB:   if (mem_gnt) state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            ST_NOT_OWNED: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = addr_q;
        mem_wdata   = buf_beat;
        mem_be      = '0;
        tx_valid    = 1'b0;
        rx_ready    = 1'b0;
        buf_load    = 1'b0;
        buf_restart = 1'b0;
        evt_set     = '0;
        unique case (state_q)
            ST_D0_REQ:   begin mem_req = 1'b1; mem_addr = base_q; end
            ST_D1_REQ:   begin mem_req = 1'b1; mem_addr = base_q + STEP; end
            ST_D1_WAIT:  buf_restart = mem_rvalid;
            ST_BUF_RD:   mem_req = 1'b1;
            ST_BUF_WAIT: buf_load = mem_rvalid;
            ST_TX_EMIT:  tx_valid = 1'b1;
            ST_RX_FILL:  rx_ready = 1'b1;
            ST_BUF_WR:   begin
                             mem_req     = 1'b1;
                             mem_we      = 1'b1;
                             mem_be      = buf_strb;
                             buf_restart = mem_gnt;
                         end
            ST_STAT_WB:  begin
                             mem_req   = 1'b1;
                             mem_we    = 1'b1;
                             mem_addr  = base_q;
                             mem_be    = WB_BE;
                             mem_wdata = BUS_W'(dstat_q & ~(32'h1 << OWNER_BIT));
                         end
            ST_FINISH:   evt_set[dir_q ? EVT_RX_DONE : EVT_TX_DONE] = 1'b1;
            ST_NOT_OWNED: evt_set[EVT_NO_DESC] = 1'b1;
            default:     ;
        endcase
    end

    assign buf_put  = rx_fire;
    assign buf_take = tx_fire;
    assign tx_data  = buf_byte;
    assign busy     = (state_q != ST_IDLE);

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            addr_q  <= '0;
            rem_q   <= '0;
            dstat_q <= '0;
            dir_q   <= 1'b0;
        end else begin
            if (cfg_we && cfg_addr == CFG_AW'(OFS_DESC_BASE))
                base_q <= ADDR_W'(cfg_wdata);
            if (state_q == ST_IDLE && start_i) begin
                dir_q <= start_dir;
                rem_q <= CNT_W'(start_len_m1) + CNT_W'(1);
            end
            if (state_q == ST_D0_WAIT && mem_rvalid)
                dstat_q <= mem_rdata[31:0];
            if (state_q == ST_D1_WAIT && mem_rvalid)
                addr_q <= ADDR_W'(mem_rdata[31:0]);
            if (tx_fire || rx_fire)
                rem_q <= rem_q - CNT_W'(1);
            if ((tx_fire && lane_last) || (state_q == ST_BUF_WR && mem_gnt))
                addr_q <= addr_q + STEP;
        end
    end

    // R2
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R5
    full_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && state_q == ST_BUF_WR && rem_q != '0 |-> (&mem_be));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start_i |=> $stable(dir_q));

endmodule

// File: tb/sdma_engine_tb.sv
`timescale 1ns/1ps
module sdma_engine_tb_top;

    localparam int NV = 12;
    localparam logic [31:0] DESC = 32'h0000_0080;
    localparam logic [31:0] SRC  = 32'h0000_0800;
    localparam logic [31:0] DST  = 32'h0000_2000;

    // {dir, own, stall, len_m1[11:0], expected status bit[3:0]}
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 12'd0,    4'd6},
        {1'b0, 1'b1, 1'b0, 12'd1,    4'd6},
        {1'b0, 1'b1, 1'b1, 12'd7,    4'd6},
        {1'b0, 1'b1, 1'b0, 12'd4094, 4'd6},
        {1'b1, 1'b1, 1'b0, 12'd0,    4'd7},
        {1'b1, 1'b1, 1'b1, 12'd1,    4'd7},
        {1'b1, 1'b1, 1'b0, 12'd7,    4'd7},
        {1'b1, 1'b1, 1'b1, 12'd4094, 4'd7},
        {1'b1, 1'b1, 1'b0, 12'd12,   4'd7},
        {1'b0, 1'b1, 1'b1, 12'd19,   4'd6},
        {1'b0, 1'b0, 1'b0, 12'd7,    4'd8},
        {1'b1, 1'b0, 1'b1, 12'd4,    4'd8}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        start_i = 1'b0;
    logic        start_dir = 1'b0;
    logic [11:0] start_len_m1 = '0;
    logic        busy;
    logic [15:0] sts_o;
    logic [15:0] sts_clr = '0;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_be;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        tx_valid, tx_ready;
    logic [7:0]  tx_data;
    logic        rx_valid, rx_ready;
    logic [7:0]  rx_data;

    sdma_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .start_i(start_i), .start_dir(start_dir), .start_len_m1(start_len_m1),
        .busy(busy), .sts_o(sts_o), .sts_clr(sts_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    function automatic logic [7:0] src_byte(input logic [31:0] a);
        return (a[7:0] * 8'd13) ^ a[12:5] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] rx_byte(input int i, input int seed);
        logic [31:0] u;
        u = 32'(i);
        return (u[7:0] * 8'd7 + 8'(seed) * 8'd31 + 8'h11) ^ u[11:4];
    endfunction

    // stall pattern
    logic phase = 1'b0;
    logic stall = 1'b0;
    always @(negedge clk) phase <= ~phase;
    assign mem_gnt  = !stall || phase;
    assign tx_ready = !stall || !phase;

    // ideal memory with backdoor loader
    logic [63:0] mem [2048];
    logic        bd_we = 1'b0;
    logic [10:0] bd_addr = '0;
    logic [63:0] bd_data = '0;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (bd_we) mem[bd_addr] <= bd_data;
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                for (int k = 0; k < 8; k++)
                    if (mem_be[k]) mem[mem_addr[13:3]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
            end else begin
                mem_rdata  <= mem[mem_addr[13:3]];
                mem_rvalid <= 1'b1;
            end
        end
    end

    // stream source and monitors
    logic        mon_clr = 1'b0;
    int          rx_len = 0;
    int          rx_seed = 0;
    int          rx_idx = 0, tx_cnt = 0, tx_err = 0, rd_cnt = 0, wr_cnt = 0;
    assign rx_valid = (rx_idx < rx_len);
    assign rx_data  = rx_byte(rx_idx, rx_seed);
    always @(posedge clk) begin
        if (mon_clr) begin
            rx_idx <= 0; tx_cnt <= 0; tx_err <= 0; rd_cnt <= 0; wr_cnt <= 0;
        end else begin
            if (mem_req && mem_gnt) begin
                if (mem_we) wr_cnt <= wr_cnt + 1;
                else        rd_cnt <= rd_cnt + 1;
            end
            if (tx_valid && tx_ready) begin
                if (tx_data !== src_byte(SRC + 32'(tx_cnt))) tx_err <= tx_err + 1;
                tx_cnt <= tx_cnt + 1;
            end
            if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
        end
    end

    int checks = 0;
    int failures = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int w = 0; w < 2048; w++) begin
            logic [63:0] d;
            for (int k = 0; k < 8; k++) d[k*8 +: 8] = src_byte(32'(w * 8 + k));
            @(negedge clk);
            bd_we = 1'b1; bd_addr = 11'(w); bd_data = d;
        end
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic put_word(input logic [31:0] a, input logic [63:0] d);
        @(negedge clk);
        bd_we = 1'b1; bd_addr = a[13:3]; bd_data = d;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic kick(input logic dir, input logic [11:0] lm1);
        @(negedge clk);
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
        start_i = 1'b1; start_dir = dir; start_len_m1 = lm1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic clear_sts();
        @(negedge clk);
        sts_clr = '1;
        @(negedge clk);
        sts_clr = '0;
    endtask

    initial begin
        int unsigned cyc;
        cyc = 0;
        while (cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", 64'(busy), 64'd0);
        chk("R11 sts", 64'(sts_o), 64'd0);
        chk("R11 idle ports", 64'({tx_valid, rx_ready, mem_req}), 64'd0);

        // R1 base at 0x18; neighbours must not disturb it
        cfg_write(8'h18, DESC);
        cfg_write(8'h1C, 32'h0000_3000);
        cfg_write(8'h10, 32'h0000_3800);

        for (int v = 0; v < NV; v++) begin
            logic        dir, own;
            logic [11:0] lm1;
            int          n, beats, mism;
            logic [3:0]  ebit;
            logic [31:0] sizes, stw;
            logic [63:0] w0;
            {dir, own, stall, lm1, ebit} = VEC[v];
            n = int'(lm1) + 1;
            beats = (n + 7) / 8;
            sizes = ((32'(n) + 32'd7) & ~32'd7) & 32'hFFF;
            stw = own ? 32'h8000_000C : 32'h0000_000C;
            rx_len = 0;
            fill_mem();
            put_word(DESC, {sizes, stw});
            put_word(DESC + 32'd8, {32'h0BAD_0000, dir ? DST : SRC});
            kick(dir, lm1);
            rx_seed = v;
            rx_len = n + 3;
            wait_idle();
            // R7 / R3 status outcome
            chk($sformatf("R7 sts vec%0d", v), 64'(sts_o), 64'(16'h1 << ebit));
            w0 = mem[DESC[13:3]];
            if (!own) begin
                chk($sformatf("R3 reads vec%0d", v), 64'(rd_cnt), 64'd1);
                chk($sformatf("R3 writes vec%0d", v), 64'(wr_cnt), 64'd0);
                chk($sformatf("R3 stream vec%0d", v), 64'(tx_cnt + rx_idx), 64'd0);
                chk($sformatf("R3 desc vec%0d", v), w0, {sizes, stw});
            end else begin
                chk($sformatf("R6 R1 writeback vec%0d", v), w0, {sizes, 32'h0000_000C});
                if (!dir) begin
                    chk($sformatf("R4 R10 tx count vec%0d", v), 64'(tx_cnt), 64'(n));
                    chk($sformatf("R4 tx data vec%0d", v), 64'(tx_err), 64'd0);
                    chk($sformatf("R2 reads vec%0d", v), 64'(rd_cnt), 64'(2 + beats));
                end else begin
                    mism = 0;
                    for (int i = 0; i < n; i++) begin
                        logic [31:0] a;
                        a = DST + 32'(i);
                        if (mem[a[13:3]][a[2:0]*8 +: 8] !== rx_byte(i, v)) mism++;
                    end
                    chk($sformatf("R5 R10 rx data vec%0d", v), 64'(mism), 64'd0);
                    chk($sformatf("R5 rx taken vec%0d", v), 64'(rx_idx), 64'(n));
                    chk($sformatf("R5 R2 rx beats vec%0d", v), 64'({rd_cnt, wr_cnt}),
                        64'({32'd2, 32'(beats + 1)}));
                    if ((n % 8) != 0) begin
                        logic [31:0] p;
                        p = DST + 32'(n);
                        chk($sformatf("R5 pad kept vec%0d", v),
                            64'(mem[p[13:3]][p[2:0]*8 +: 8]), 64'(src_byte(p)));
                    end
                end
            end
            clear_sts();
            chk($sformatf("R8 cleared vec%0d", v), 64'(sts_o), 64'd0);
        end
        stall = 1'b0;

        // R9 start ignored while busy
        rx_len = 0;
        put_word(DESC, {32'd200, 32'h8000_000C});
        put_word(DESC + 32'd8, {32'd0, SRC});
        kick(1'b0, 12'd199);
        repeat (5) @(negedge clk);
        start_i = 1'b1; start_dir = 1'b1; start_len_m1 = 12'd2;
        @(negedge clk);
        start_i = 1'b0;
        rx_len = 10;
        wait_idle();
        @(negedge clk);
        chk("R9 only tx done", 64'(sts_o), 64'h40);
        chk("R9 no rx taken", 64'(rx_idx), 64'd0);
        chk("R9 tx count", 64'(tx_cnt), 64'd200);
        clear_sts();

        // R8 set and clear in the same cycle
        rx_len = 0;
        put_word(DESC, {32'd8, 32'h8000_000C});
        @(negedge clk);
        sts_clr = 16'h0040;
        kick(1'b0, 12'd7);
        wait_idle();
        chk("R8 set wins", 64'(sts_o[6]), 64'd1);
        @(negedge clk);
        chk("R8 clear after", 64'(sts_o[6]), 64'd0);
        sts_clr = '0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule